// File: doc/BRIEF.md
# Horizontal Microword Datapath Slice

This block is one slice of a datapath in which every control point is wired straight from a field of a wide, unencoded microinstruction. In each clock cycle the caller presents one 14-bit word. The slice reads one word from a local data memory and forms a constant. It then adds or subtracts that constant and, if the word asks for it, stores the result in an 8-bit result register. Every operation is one register transfer that completes at the clock edge following the cycle in which the word is presented.

The constant comes from one of two sources. The first is the 8-bit upper field of the word taken as a raw value. The second is a small decoder that turns a 3-bit exponent field into a power of two. The upper field is also the memory read address. A word that takes its constant from the raw field therefore always uses that same value as its address. The memory is filled through its own write port, which is independent of the microword.

Top module: `uslice_top`

## Requirements
- R1: A synchronous, active-high `rst` clears the result register to 0 at the next rising edge, even when the load bit of that cycle's word is 1.
- R2: Word bits 13..6 form the read address of a 256 x 8 data memory. The memory read is combinational, so the word presented in a cycle uses that cycle's stored contents.
- R3: With word bit 0 = 0, the constant operand is the value of bits 13..6, which is the same value used as the read address.
- R4: With word bit 0 = 1, the constant operand is 2 raised to the value of bits 5..3 (exponent 0 gives 1, 6 gives 64, 7 gives 128).
- R5: With word bit 1 = 0, the stored result is the memory read data minus the constant operand, taken modulo 256.
- R6: With word bit 1 = 1, the stored result is the memory read data plus the constant operand, taken modulo 256.
- R7: With word bit 2 = 0 (and reset low), the result register keeps its value whatever the other word bits and write-port inputs are.
- R8: When `memWrEn` is 1, `memWrData` is written to address `memWrAddr` at the rising edge. A word that reads the same address in that cycle sees the old contents, and later cycles see the new value.
- R9: With word bit 2 = 1, the result register takes the new value at the first rising edge after the word is presented. There is no extra pipeline stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the result register |
| instrWord | input | 14 | Microinstruction: [13:6] address/immediate, [5:3] exponent, [2] load, [1] ALU mode, [0] constant select |
| memWrEn | input | 1 | Data memory write enable |
| memWrAddr | input | 8 | Data memory write address |
| memWrData | input | 8 | Data memory write data |
| resultR | output | 8 | Result register contents |

## Verification
The bench goes after the shared field. A slice that decoded the raw constant from a different bit range than the address would subtract the wrong value whenever bit 0 is 0. All eight exponent codes are tried, including 7, which gives 128. A decoder that shifted by one, or that truncated the top code, would give a visibly wrong sum. Subtractions that underflow and additions that overflow are forced, so that arithmetic which saturated or widened would show. Writing and reading one address in the same cycle catches a memory that forwards the new data. A cycle with reset and load both high catches a design where the load beats the reset.

// File: rtl/uslice_pkg.sv
package uslice_pkg;

  // ALU operation picked by the mode bit of the microword.
  typedef enum logic {
    ALU_SUB = 1'b0,
    ALU_ADD = 1'b1
  } aluOp_t;

  // Strobes handed from the field decoder to the datapath.
  typedef struct packed {
    logic   loadR;       // capture ALU result at the edge
    aluOp_t aluOp;       // subtract or add
    logic   pickDecoded; // 1: power-of-two constant, 0: raw field
  } ctrlStrobes_t;

endpackage

// File: rtl/uslice_ctrl.sv
module uslice_ctrl
  import uslice_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int EXP_W   = 3,
  localparam int INSTR_W = FIELD_W + EXP_W + 3
) (
  input  logic [INSTR_W-1:0] instrWord,
  output ctrlStrobes_t       strobes,
  output logic [FIELD_W-1:0] fieldVal,
  output logic [EXP_W-1:0]   expVal
);

  // Bit positions of the single-bit control fields.
  localparam int SEL_BIT  = 0;
  localparam int MODE_BIT = 1;
  localparam int LOAD_BIT = 2;
  localparam int EXP_LO   = 3;
  localparam int EXP_HI   = EXP_LO + EXP_W - 1;
  localparam int FIELD_LO = EXP_HI + 1;
  localparam int FIELD_HI = FIELD_LO + FIELD_W - 1;

  always_comb begin
    strobes.loadR       = instrWord[LOAD_BIT];
    strobes.aluOp       = aluOp_t'(instrWord[MODE_BIT]);
    strobes.pickDecoded = instrWord[SEL_BIT];
    fieldVal            = instrWord[FIELD_HI:FIELD_LO];
    expVal              = instrWord[EXP_HI:EXP_LO];
  end

endmodule

// File: rtl/uslice_dpath.sv
module uslice_dpath
  import uslice_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FIELD_W = 8,
  parameter int EXP_W   = 3,
  localparam int DEPTH  = 1 << FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [FIELD_W-1:0] fieldVal,
  input  logic [EXP_W-1:0]   expVal,
  input  logic               memWrEn,
  input  logic [FIELD_W-1:0] memWrAddr,
  input  logic [DATA_W-1:0]  memWrData,
  output logic [DATA_W-1:0]  memRdData,
  output logic [DATA_W-1:0]  resultR
);

  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [DATA_W-1:0] pow2Const;
  logic [DATA_W-1:0] rawConst;
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] aluOut;

  // Data memory: synchronous write, combinational read.
  always_ff @(posedge clk) begin
    if (memWrEn) dataMem[memWrAddr] <= memWrData;
  end

  assign memRdData = dataMem[fieldVal];

  // Power-of-two decoder: one output bit per exponent code.
  for (genvar i = 0; i < DATA_W; i++) begin : gPow2
    if (i < (1 << EXP_W)) begin : gLive
      assign pow2Const[i] = (expVal == EXP_W'(i));
    end else begin : gDead
      assign pow2Const[i] = 1'b0;
    end
  end

  // Raw immediate, fitted to the data width.
  if (FIELD_W >= DATA_W) begin : gRawTrim
    assign rawConst = fieldVal[DATA_W-1:0];
  end else begin : gRawExt
    assign rawConst = {{(DATA_W-FIELD_W){1'b0}}, fieldVal};
  end

  // Operand multiplexer and ALU.
  always_comb begin
    operandB = strobes.pickDecoded ? pow2Const : rawConst;
    unique case (strobes.aluOp)
      ALU_ADD: aluOut = memRdData + operandB;
      default: aluOut = memRdData - operandB;
    endcase
  end

  // Result register.
  always_ff @(posedge clk) begin
    if (rst)                resultR <= '0;
    else if (strobes.loadR) resultR <= aluOut;
  end

endmodule

// File: rtl/uslice_top.sv
module uslice_top
  import uslice_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [13:0] instrWord,
  input  logic        memWrEn,
  input  logic [7:0]  memWrAddr,
  input  logic [7:0]  memWrData,
  output logic [7:0]  resultR
);

  localparam int DATA_W  = 8;
  localparam int FIELD_W = 8;
  localparam int EXP_W   = 3;

  ctrlStrobes_t       strobes;
  logic [FIELD_W-1:0] fieldVal;
  logic [EXP_W-1:0]   expVal;
  logic [DATA_W-1:0]  memRdData;

  uslice_ctrl #(.FIELD_W(FIELD_W), .EXP_W(EXP_W)) uCtrl (
    .instrWord (instrWord),
    .strobes   (strobes),
    .fieldVal  (fieldVal),
    .expVal    (expVal)
  );

  uslice_dpath #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .EXP_W(EXP_W)) uDpath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .fieldVal  (fieldVal),
    .expVal    (expVal),
    .memWrEn   (memWrEn),
    .memWrAddr (memWrAddr),
    .memWrData (memWrData),
    .memRdData (memRdData),
    .resultR   (resultR)
  );

endmodule

// File: rtl/uslice_chk.sv
module uslice_chk (
  input logic        clk,
  input logic        rst,
  input logic [13:0] instrWord,
  input logic [7:0]  memRdData,
  input logic [7:0]  resultR
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> resultR == 8'd0); // R1

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    !instrWord[2] |=> $stable(resultR)); // R7

  AST_SUB_RAW: assert property (@(posedge clk) disable iff (rst)
    (instrWord[2] && !instrWord[1] && !instrWord[0]) |=>
      resultR == 8'($past(memRdData) - $past(instrWord[13:6]))); // R5

  AST_ADD_RAW: assert property (@(posedge clk) disable iff (rst)
    (instrWord[2] && instrWord[1] && !instrWord[0]) |=>
      resultR == 8'($past(memRdData) + $past(instrWord[13:6]))); // R3

  AST_ADD_POW2: assert property (@(posedge clk) disable iff (rst)
    (instrWord[2] && instrWord[1] && instrWord[0]) |=>
      resultR == 8'($past(memRdData) + (8'd1 << $past(instrWord[5:3])))); // R4

  AST_SUB_POW2: assert property (@(posedge clk) disable iff (rst)
    (instrWord[2] && !instrWord[1] && instrWord[0]) |=>
      resultR == 8'($past(memRdData) - (8'd1 << $past(instrWord[5:3])))); // R9

endmodule

bind uslice_top uslice_chk uChk (
  .clk       (clk),
  .rst       (rst),
  .instrWord (instrWord),
  .memRdData (memRdData),
  .resultR   (resultR)
);

// File: tb/uslice_top_test.sv
module uslice_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] instrWord = '0;
  logic        memWrEn = 1'b0;
  logic [7:0]  memWrAddr = '0;
  logic [7:0]  memWrData = '0;
  logic [7:0]  resultR;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int refMem [256];
  int refR = 0;

  always #2.5 clk = ~clk;

  uslice_top uut (
    .clk(clk), .rst(rst), .instrWord(instrWord),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .resultR(resultR)
  );

  function automatic logic [13:0] mk(input int f, input int ex,
                                     input bit load, input bit mode, input bit sel);
    return {8'(f), 3'(ex), load, mode, sel};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: resultR=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock of stimulus plus the reference model, compared after the edge.
  task automatic step(input string tag, input logic [13:0] iw, input bit r,
                      input bit we, input int wa, input int wd);
    int f, ex, op, nextR;
    @(negedge clk);
    instrWord = iw; rst = r; memWrEn = we;
    memWrAddr = 8'(wa); memWrData = 8'(wd);
    f  = int'(iw[13:6]);
    ex = int'(iw[5:3]);
    op = iw[0] ? (1 << ex) : f;
    nextR = refR;
    if (r) nextR = 0;
    else if (iw[2]) nextR = iw[1] ? (refMem[f] + op) % 256
                                  : (refMem[f] - op + 256) % 256;
    @(posedge clk);
    refR = nextR;
    if (we) refMem[wa] = wd;
    #1 check(tag, int'(resultR), refR);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) refMem[i] = 0;
    // R1: reset state
    step("R1", mk(0, 0, 1, 1, 1), 1'b1, 0, 0, 0);
    step("R1", '0, 1'b1, 0, 0, 0);

    // R8 / R7: fill memory with loads off, R must hold
    for (int i = 0; i < 256; i++)
      step("R7", mk(255 - i, i % 8, 0, i % 2, 1), 1'b0, 1, i, (i * 37 + 11) % 256);

    // R3, R5: subtract raw field (address 5)
    step("R5", mk(5, 0, 1, 0, 0), 1'b0, 0, 0, 0);
    // R3, R6: add raw field, overflow at address 255
    step("R6", mk(255, 2, 1, 1, 0), 1'b0, 0, 0, 0);
    // R4, R6: every exponent code
    for (int e = 0; e < 8; e++)
      step("R4", mk(40 + e, e, 1, 1, 1), 1'b0, 0, 0, 0);
    // R4, R5: subtract 128 from a small value (underflow)
    step("R8", mk(9, 0, 0, 0, 0), 1'b0, 1, 9, 3);
    step("R5", mk(9, 7, 1, 0, 1), 1'b0, 0, 0, 0);
    // R7: hold with every other field toggling
    for (int k = 0; k < 6; k++)
      step("R7", mk(k * 50, k, 0, k % 2, k / 3), 1'b0, 1, 200 + k, k);
    // R8: write and read same address in one cycle sees old data
    step("R8", mk(77, 0, 1, 1, 0), 1'b0, 1, 77, 200);
    step("R8", mk(77, 0, 1, 1, 0), 1'b0, 0, 0, 0);
    // R9: back-to-back loads each land after one edge
    step("R9", mk(1, 1, 1, 0, 1), 1'b0, 0, 0, 0);
    step("R9", mk(2, 3, 1, 1, 1), 1'b0, 0, 0, 0);
    // R2: random traffic against the model
    for (int n = 0; n < 400; n++)
      step("R2", 14'($urandom), 1'b0, bit'($urandom % 3 == 0),
           int'($urandom % 256), int'($urandom % 256));
    // R1: reset beats load mid-run
    step("R6", mk(100, 0, 1, 1, 0), 1'b0, 0, 0, 0);
    step("R1", mk(100, 0, 1, 1, 0), 1'b1, 0, 0, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule